// File: doc/BRIEF.md
# Serial Byte Stream Receiver with Request Flow Control

This block takes in a compressed audio byte stream that arrives one bit at a time on a serial data line. A bit clock and a byte-sync strobe travel with the data. The bit clock is either driven by the host (slave mode) or generated by the block and sent out to the host (master mode). In master mode a mode input picks one of two bit rates. The data line is sampled on the rising or the falling edge of the bit clock, as a mode input selects. Each group of eight sampled bits becomes one byte, most or least significant bit first. The sync strobe restarts the byte, so a host can always realign after a glitch.

Finished bytes are written into a 256-entry on-chip FIFO. The consumer reads them from the head with a simple valid/enable handshake. A request output stays high while the FIFO has room for at least a 32-byte burst, so the host can send blindly once it sees the request. A byte that finishes while the FIFO is full is thrown away and latches an overflow flag.

Top module: `serial_byte_rx`

## Requirements
- R1: After reset, `level` is 0, `rd_valid` is 0, `overflow` is 0, `dreq` is 1 and `dclk_out` is 0.
- R2: The bit clock, data and sync inputs pass through two synchronizer flops, which reset low. A bit-clock edge presented before core clock edge n takes effect at edge n+2, using the data and sync values presented with it. With `mode_fall_edge`=0 only low-to-high transitions sample data. With 1 only high-to-low transitions sample data.
- R3: With `mode_lsb_first`=0 the first sampled bit of a byte lands in bit 7 of the byte. With 1 it lands in bit 0.
- R4: A sampled bit with `bsync` high becomes the first bit of a new byte, and any partly assembled bits are discarded. The eighth sampled bit after the strobe completes the byte.
- R5: Completed bytes leave on `rd_data` in arrival order. `rd_data` shows the oldest byte while `rd_valid` is high. `rd_en` with `rd_valid` removes that byte at the clock edge. `level` gives the number of stored bytes and changes by at most one per cycle.
- R6: `dreq` is high exactly when 256 minus `level` is at least 32. This means it is high up to a level of 224 and low from 225 on.
- R7: A byte that completes while `level` is 256 before the edge is dropped, even if a read happens in the same cycle. That byte sets `overflow`, which stays high until reset.
- R8: In master mode `dclk_out` toggles every CORE_HZ/(2·512000) core cycles with `mode_fast_clk`=0, and every CORE_HZ/(2·1024000) cycles with 1. In slave mode `dclk_out` is held low from the cycle after the mode input drops.
- R9: In master mode the generated clock does the sampling and transitions on `ext_dclk` have no effect.
- R10: `rd_en` while the FIFO is empty leaves `level` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_master | input | 1 | 1: the block generates the bit clock; 0: it is taken from `ext_dclk` |
| mode_fast_clk | input | 1 | Master bit rate: 0 is 512 kHz, 1 is 1024 kHz |
| mode_fall_edge | input | 1 | 0: sample on rising bit-clock edge; 1: on falling edge |
| mode_lsb_first | input | 1 | 0: first bit is MSB; 1: first bit is LSB |
| ext_dclk | input | 1 | Bit clock from the host in slave mode |
| sdata | input | 1 | Serial data |
| bsync | input | 1 | Byte-sync strobe, high with the first bit of a byte |
| dclk_out | output | 1 | Generated bit clock in master mode, low otherwise |
| rd_en | input | 1 | Pops the head byte when `rd_valid` is high |
| rd_data | output | 8 | Oldest stored byte |
| rd_valid | output | 1 | FIFO not empty |
| level | output | 9 | Number of stored bytes |
| dreq | output | 1 | Room for at least 32 more bytes |
| overflow | output | 1 | Sticky: a byte was dropped on a full FIFO |

## Verification
The hardest state to reach from the ports is a byte that completes exactly at the full boundary. To get there, the bench pushes 256 bytes through the serial pins with no reads, then sends a 257th byte, and checks that it is dropped while the stored bytes keep their order. The request boundary is crossed on the same run, at 224 and then 225 stored bytes. In master mode the host has to follow the generated clock. The bench launches each bit on a falling edge it sees on `dclk_out`, while toggling `ext_dclk` the whole time, and holds the sync strobe high while idle so the free-running clock pushes no stray bytes. A behavioural queue model, fed from the port values, is compared with the outputs on every cycle.

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
  parameter int CORE_HZ = 200_000_000,
  parameter int DEPTH   = 256,
  parameter int ROOM    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_master,
  input  logic                     mode_fast_clk,
  input  logic                     mode_fall_edge,
  input  logic                     mode_lsb_first,
  input  logic                     ext_dclk,
  input  logic                     sdata,
  input  logic                     bsync,
  output logic                     dclk_out,
  input  logic                     rd_en,
  output logic [7:0]               rd_data,
  output logic                     rd_valid,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     dreq,
  output logic                     overflow
);
  localparam int AW        = $clog2(DEPTH);
  localparam int LW        = AW + 1;
  localparam int HALF_SLOW = CORE_HZ / (2 * 512_000);
  localparam int HALF_FAST = CORE_HZ / (2 * 1_024_000);
  localparam int CW        = $clog2(HALF_SLOW + 1);

  logic [CW-1:0] div_cnt;
  logic          dclk_gen;
  logic [2:0]    ck_q;
  logic [1:0]    sd_q, sy_q;
  logic [7:0]    shreg;
  logic [2:0]    bcnt;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] count;

  wire [CW-1:0] half_m1 = mode_fast_clk ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt  <= '0;
      dclk_gen <= 1'b0;
    end else if (!mode_master) begin
      div_cnt  <= '0;
      dclk_gen <= 1'b0;
    end else if (div_cnt >= half_m1) begin
      div_cnt  <= '0;
      dclk_gen <= ~dclk_gen;
    end else begin
      div_cnt  <= div_cnt + 1'b1;
    end

  assign dclk_out = dclk_gen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_q <= '0;
      sd_q <= '0;
      sy_q <= '0;
    end else begin
      ck_q <= {ck_q[1:0], mode_master ? dclk_gen : ext_dclk};
      sd_q <= {sd_q[0], sdata};
      sy_q <= {sy_q[0], bsync};
    end

  wire rise   = ck_q[1] & ~ck_q[2];
  wire fall   = ~ck_q[1] & ck_q[2];
  wire take   = mode_fall_edge ? fall : rise;
  wire bit_in = sd_q[1];
  wire sync   = sy_q[1];
  wire [7:0] shifted = mode_lsb_first ? {bit_in, shreg[7:1]} : {shreg[6:0], bit_in};
  wire done   = take & ~sync & (bcnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0;
      bcnt  <= '0;
    end else if (take) begin
      shreg <= shifted;
      bcnt  <= sync ? 3'd1 : bcnt + 3'd1;
    end

  wire full  = (count == LW'(DEPTH));
  wire empty = (count == '0);
  wire push  = done & ~full;
  wire pop   = rd_en & ~empty;

  always_ff @(posedge clk)
    if (push) mem[wptr] <= shifted;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      count    <= count + LW'(push) - LW'(pop);
      overflow <= overflow | (done & full);
    end

  assign rd_data  = mem[rptr];
  assign rd_valid = ~empty;
  assign level    = count;
  assign dreq     = (LW'(DEPTH) - count) >= LW'(ROOM);
endmodule

// File: rtl/serial_byte_rx_chk.sv
module serial_byte_rx_chk #(
  parameter int DEPTH = 256
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mode_master,
  input logic                   rd_en,
  input logic                   rd_valid,
  input logic                   overflow,
  input logic                   dclk_out,
  input logic [$clog2(DEPTH):0] level
);
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R7
  AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(overflow) |-> int'($past(level)) == DEPTH); // R7
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) == int'($past(level))) || (int'(level) == int'($past(level)) + 1) || (int'(level) + 1 == int'($past(level)))); // R5
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) (!rd_valid && rd_en) |=> int'(level) <= 1); // R10
  AST_SLAVE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) !mode_master |=> !dclk_out); // R8
endmodule

bind serial_byte_rx serial_byte_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .rd_en(rd_en),
  .rd_valid(rd_valid), .overflow(overflow), .dclk_out(dclk_out), .level(level)
);

// File: tb/tb_serial_byte_rx.sv
`timescale 1ns/1ps
module tb_serial_byte_rx;
  localparam int CORE  = 8_192_000;
  localparam int DEPTH = 256;
  localparam int ROOM  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_master = 0, mode_fast_clk = 0, mode_fall_edge = 0, mode_lsb_first = 0;
  logic ext_dclk = 0, sdata = 0, bsync = 0, rd_en = 0;
  logic dclk_out, rd_valid, dreq, overflow;
  logic [7:0] rd_data;
  logic [8:0] level;

  always #2.5 clk = ~clk;

  serial_byte_rx #(.CORE_HZ(CORE), .DEPTH(DEPTH), .ROOM(ROOM)) dut (
    .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .mode_fast_clk(mode_fast_clk),
    .mode_fall_edge(mode_fall_edge), .mode_lsb_first(mode_lsb_first), .ext_dclk(ext_dclk),
    .sdata(sdata), .bsync(bsync), .dclk_out(dclk_out), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .level(level), .dreq(dreq), .overflow(overflow)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  q[$];
  int  m_bits, m_sh;
  bit  m_ovf, m_master;
  bit  h1, h2, h3, d1, d2, s1, s2;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_bits = 0; m_sh = 0; m_ovf = 0; m_master = 0;
      h1 = 0; h2 = 0; h3 = 0; d1 = 0; d2 = 0; s1 = 0; s2 = 0;
    end else begin
      bit full, take;
      full = (q.size() == DEPTH);
      take = mode_fall_edge ? (!h2 && h3) : (h2 && !h3);
      if (rd_en && q.size() > 0) void'(q.pop_front());
      if (take) begin
        if (mode_lsb_first) m_sh = (m_sh >> 1) | (int'(d2) << 7);
        else                m_sh = ((m_sh << 1) | int'(d2)) & 255;
        if (s2) m_bits = 1;
        else if (m_bits == 7) begin
          m_bits = 0;
          if (full) m_ovf = 1;
          else q.push_back(m_sh);
        end else m_bits++;
      end
      h3 = h2; h2 = h1; h1 = mode_master ? dclk_out : ext_dclk;
      d2 = d1; d1 = sdata; s2 = s1; s1 = bsync;
      m_master = mode_master;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(int'(level) == q.size(), "R5 level", level, q.size());
      check(rd_valid == (q.size() > 0), "R5 rd_valid", rd_valid, q.size() > 0);
      if (q.size() > 0) check(int'(rd_data) == q[0], "R5 rd_data", rd_data, q[0]);
      check(dreq == ((DEPTH - q.size()) >= ROOM), "R6 dreq", dreq, (DEPTH - q.size()) >= ROOM);
      check(overflow == m_ovf, "R7 overflow", overflow, m_ovf);
      if (!m_master) check(dclk_out == 1'b0, "R8 dclk_out slave", dclk_out, 0);
    end
  end

  task automatic do_reset();
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send_bit(bit b, bit s);
    sdata = b; bsync = s;
    repeat (2) @(negedge clk);
    ext_dclk = ~ext_dclk;
    repeat (2) @(negedge clk);
    ext_dclk = ~ext_dclk;
    @(negedge clk);
  endtask

  task automatic send_byte(int v, bit s);
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = mode_lsb_first ? i : 7 - i;
      send_bit(v[idx], s && i == 0);
    end
    bsync = 0;
  endtask

  task automatic pop_expect(int exp, string tag);
    repeat (4) @(negedge clk);
    check(rd_valid == 1'b1, tag, rd_valid, 1);
    check(int'(rd_data) == exp, tag, rd_data, exp);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_gen_fall();
    bit prev;
    do begin
      prev = dclk_out;
      @(negedge clk);
    end while (!(prev && !dclk_out));
  endtask

  task automatic m_send_byte(int v);
    for (int i = 0; i < 8; i++) begin
      wait_gen_fall();
      sdata = v[7 - i]; bsync = (i == 0);
      ext_dclk = ~ext_dclk;
    end
    wait_gen_fall();
    bsync = 1; sdata = 0; ext_dclk = ~ext_dclk;
  endtask

  task automatic measure_period(output int n);
    bit prev;
    do begin prev = dclk_out; @(negedge clk); end while (!(!prev && dclk_out));
    n = 0;
    do begin prev = dclk_out; @(negedge clk); n++; end while (!(!prev && dclk_out));
  endtask

  function automatic int pat(int i);
    return (i * 37 + 11) & 255;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int per;
    @(negedge clk);
    do_reset();
    // R1 reset state
    check(level == 0, "R1 level", level, 0);
    check(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
    check(overflow == 0, "R1 overflow", overflow, 0);
    check(dreq == 1, "R1 dreq", dreq, 1);
    check(dclk_out == 0, "R1 dclk_out", dclk_out, 0);

    // R10 read on empty
    rd_en = 1; repeat (3) @(negedge clk); rd_en = 0; @(negedge clk);
    check(level == 0, "R10 empty read", level, 0);

    // R2 R3 rising edge, MSB first
    send_byte(8'hA5, 1);
    send_byte(8'h3C, 1);
    pop_expect(8'hA5, "R3 msb byte0");
    pop_expect(8'h3C, "R3 msb byte1");

    // R3 bit position of first bit
    send_bit(1, 1); for (int i = 0; i < 7; i++) send_bit(0, 0);
    pop_expect(8'h80, "R3 msb first bit -> bit7");
    mode_lsb_first = 1;
    send_bit(1, 1); for (int i = 0; i < 7; i++) send_bit(0, 0);
    pop_expect(8'h01, "R3 lsb first bit -> bit0");
    send_byte(8'hC4, 1);
    pop_expect(8'hC4, "R3 lsb byte");

    // R2 falling-edge sampling
    mode_lsb_first = 0;
    mode_fall_edge = 1; ext_dclk = 1;
    repeat (4) @(negedge clk);
    send_byte(8'h5A, 1);
    pop_expect(8'h5A, "R2 falling edge byte");
    mode_fall_edge = 0; ext_dclk = 0;
    repeat (4) @(negedge clk);

    // R4 resync discards partial byte
    send_bit(1, 1); send_bit(1, 0); send_bit(1, 0);
    send_byte(8'h42, 1);
    repeat (4) @(negedge clk);
    check(level == 1, "R4 one byte after resync", level, 1);
    pop_expect(8'h42, "R4 realigned byte");

    // R6 R7 fill to the boundary and beyond
    for (int i = 0; i < 224; i++) send_byte(pat(i), 1);
    repeat (4) @(negedge clk);
    check(level == 224, "R6 level 224", level, 224);
    check(dreq == 1, "R6 dreq at 224", dreq, 1);
    send_byte(pat(224), 1);
    repeat (4) @(negedge clk);
    check(dreq == 0, "R6 dreq at 225", dreq, 0);
    for (int i = 225; i < 256; i++) send_byte(pat(i), 1);
    repeat (4) @(negedge clk);
    check(level == 256, "R7 full", level, 256);
    check(overflow == 0, "R7 no overflow yet", overflow, 0);
    send_byte(8'hEE, 1);
    repeat (4) @(negedge clk);
    check(level == 256, "R7 dropped byte", level, 256);
    check(overflow == 1, "R7 overflow set", overflow, 1);
    pop_expect(pat(0), "R7 head kept");
    check(overflow == 1, "R7 sticky", overflow, 1);
    rd_en = 1;
    repeat (255) @(negedge clk);
    rd_en = 0; @(negedge clk);
    check(level == 0, "R5 drained", level, 0);

    // R8 R9 master mode
    bsync = 1;
    do_reset();
    mode_master = 1; mode_fast_clk = 0;
    measure_period(per);
    check(per == 2 * (CORE / (2 * 512_000)), "R8 slow period", per, CORE / 512_000);
    mode_fast_clk = 1;
    measure_period(per);
    measure_period(per);
    check(per == 2 * (CORE / (2 * 1_024_000)), "R8 fast period", per, CORE / 1_024_000);
    check(level == 0, "R9 idle sync gives no bytes", level, 0);
    m_send_byte(8'h96);
    m_send_byte(8'h1F);
    repeat (20) @(negedge clk);
    check(level == 2, "R9 master bytes", level, 2);
    pop_expect(8'h96, "R9 master byte0");
    pop_expect(8'h1F, "R9 master byte1");
    mode_master = 0;
    repeat (3) @(negedge clk);
    check(dclk_out == 0, "R8 slave clock low", dclk_out, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule